// File: doc/BRIEF.md
# Calorimeter Coincidence Level-Two Trigger

This block forms a second-level trigger by pairing discriminated sum bits from a hadron calorimeter with those from an electron calorimeter. The detector is divided into sections. Each section brings a vector of hadron sum bits and a vector of electron sum bits. The electron bits are produced early, so each section first passes them through a programmable ring-buffer delay. The hadron sums come from a slow digital summing stage, and the delay brings the electron bits level with them.

After the delay, every electron bit is held open for a short coincidence window. A hadron bit counts as a coincidence only when two things are true: an electron bit of the same section is open in that cycle, and a loadable correlation map permits that particular (hadron, electron) pair. One map is shared by all sections, because their geometry repeats. The coincidences of all sections are ORed together.

A level-one trigger opens a decision period of fixed length. A coincidence inside that period produces a one-cycle level-two accept. If the period runs out first, the block produces a one-cycle fast-clear request instead. Two saturating counters record the number of accepts and the number of timeouts.

Top module: `cc_l2_trigger`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `l2_accept`, `fast_clear`, `acc_cnt` and `tmo_cnt` are zero. Reset also clears every correlation-map row, so with no later map write no pair can ever cause an accept.
- R2: Let an electron bit be sampled at clock edge c, with `dly_cfg` = D. It pairs with a hadron bit sampled at edge h only when h - c - D lies between 1 and WIN inclusive (WIN defaults to 8 cycles). Outside that range the pair does not count.
- R3: Hadron bit h and electron bit e pair only when bit e of map row h is 1. A clock edge with `map_we` high loads `map_data` into row `map_row`, where bit e of `map_data` stands for electron bit e.
- R4: Section s owns hadron bits s*N_HAD+h of `had_bits` and electron bits s*N_EL+e of `el_bits`. Bits from different sections never pair. A coincidence in any one section is enough to give an accept.
- R5: Let `l1_trig` be sampled at edge L while the block is idle. A coincidence whose hadron bit is sampled at edge h, with h+2 <= L+TMO, drives `l2_accept` high for exactly one cycle, starting at edge h+2. This ends the decision period.
- R6: If no accept occurs by edge L+TMO (TMO defaults to 200 cycles), `fast_clear` goes high for exactly one cycle starting at edge L+TMO, and the block returns to idle.
- R7: A coincidence that arrives while the block is idle has no effect. A `l1_trig` that arrives during an open decision period has no effect either: it neither restarts nor extends the period.
- R8: `acc_cnt` increases by one with each accept and `tmo_cnt` increases by one with each fast clear. Each counter stops at its all-ones value.
- R9: `l2_accept` and `fast_clear` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_cfg | input | $clog2(DLY_DEPTH) | Electron delay in cycles |
| map_we | input | 1 | Correlation-map row write strobe |
| map_row | input | $clog2(N_HAD) | Map row (hadron index) to write |
| map_data | input | N_EL | Row contents, bit e allows electron e |
| l1_trig | input | 1 | Level-one trigger, opens a decision period |
| el_bits | input | N_SEC*N_EL | Discriminated electron sum bits, all sections |
| had_bits | input | N_SEC*N_HAD | Discriminated hadron sum bits, all sections |
| l2_accept | output | 1 | One-cycle level-two accept |
| fast_clear | output | 1 | One-cycle timeout, requests a fast clear |
| acc_cnt | output | CNT_W | Saturating count of accepts |
| tmo_cnt | output | CNT_W | Saturating count of timeouts |

## Verification
The exact edge of every accept and every fast clear is measured against the expected edge. Because of this, a delay pointer that is off by one, or a window counter that is loaded with the wrong value, shows up as an accept that moves by a cycle or appears or disappears at the window boundary. A wrong map row or a mix-up between sections shows up as an accept where a fast clear was expected, no later than TMO cycles after the level-one trigger. A controller stuck in the wrong state shows at the ports as a missing, doubled or late fast clear, and the saturating counters make any miscount visible after each case.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic {
        DEC_IDLE,
        DEC_WAIT
    } dec_state_e;

    typedef struct packed {
        logic accept;
        logic clear;
    } dec_out_t;

    function automatic int cnt_bits(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/cc_el_delay.sv
module cc_el_delay #(
    parameter int N_EL      = 36,
    parameter int DLY_DEPTH = 256,
    parameter int WIN       = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DLY_DEPTH)-1:0] dly,
    input  logic [N_EL-1:0]              el_in,
    output logic [N_EL-1:0]              win_open
);
    localparam int AW  = $clog2(DLY_DEPTH);
    localparam int WCW = cc_pkg::cnt_bits(WIN);

    logic [N_EL-1:0] ring [DLY_DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic [N_EL-1:0] el_d;

    assign rp = wp - dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            el_d <= '0;
            for (int i = 0; i < DLY_DEPTH; i++) ring[i] <= '0;
        end else begin
            wp       <= wp + 1'b1;
            ring[wp] <= el_in;
            el_d     <= (dly == '0) ? el_in : ring[rp];
        end
    end

    // Each delayed electron bit holds its window open for WIN cycles.
    for (genvar e = 0; e < N_EL; e++) begin : g_stretch
        logic [WCW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)          cnt <= '0;
            else if (el_d[e]) cnt <= WCW'(WIN);
            else if (cnt != '0) cnt <= cnt - 1'b1;
        end
        assign win_open[e] = (cnt != '0);
    end

endmodule

// File: rtl/cc_corr_map.sv
module cc_corr_map #(
    parameter int N_HAD = 49,
    parameter int N_EL  = 36
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(N_HAD)-1:0] row,
    input  logic [N_EL-1:0]          data,
    output logic [N_HAD*N_EL-1:0]    map_flat
);
    localparam int RW = $clog2(N_HAD);

    for (genvar h = 0; h < N_HAD; h++) begin : g_row
        logic [N_EL-1:0] bits_q;
        always_ff @(posedge clk) begin
            if (rst)                          bits_q <= '0;
            else if (we && row == RW'(h))     bits_q <= data;
        end
        assign map_flat[h*N_EL +: N_EL] = bits_q;
    end

endmodule

// File: rtl/cc_sec_match.sv
module cc_sec_match #(
    parameter int N_HAD = 49,
    parameter int N_EL  = 36
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_HAD-1:0]      had_in,
    input  logic [N_EL-1:0]       win_open,
    input  logic [N_HAD*N_EL-1:0] map_flat,
    output logic                  sec_hit
);
    logic [N_HAD-1:0] had_q;
    logic [N_HAD-1:0] row_hit;

    for (genvar h = 0; h < N_HAD; h++) begin : g_pair
        assign row_hit[h] = had_q[h] & |(map_flat[h*N_EL +: N_EL] & win_open);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            had_q   <= '0;
            sec_hit <= 1'b0;
        end else begin
            had_q   <= had_in;
            sec_hit <= |row_hit;
        end
    end

endmodule

// File: rtl/cc_decide.sv
module cc_decide
    import cc_pkg::*;
#(
    parameter int TMO   = 200,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             l1,
    input  logic             any_hit,
    output logic             accept,
    output logic             clear,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] tmo_cnt
);
    localparam int TW = cnt_bits(TMO);

    dec_state_e    st;
    logic [TW-1:0] tcnt;
    dec_out_t      dq;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= DEC_IDLE;
            tcnt    <= '0;
            dq      <= '0;
            acc_cnt <= '0;
            tmo_cnt <= '0;
        end else begin
            dq <= '0;
            unique case (st)
                DEC_IDLE: begin
                    if (l1) begin
                        st   <= DEC_WAIT;
                        tcnt <= '0;
                    end
                end
                DEC_WAIT: begin
                    if (any_hit) begin
                        dq.accept <= 1'b1;
                        st        <= DEC_IDLE;
                        if (acc_cnt != '1) acc_cnt <= acc_cnt + 1'b1;
                    end else if (tcnt == TW'(TMO - 1)) begin
                        dq.clear <= 1'b1;
                        st       <= DEC_IDLE;
                        if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= DEC_IDLE;
            endcase
        end
    end

    assign accept = dq.accept;
    assign clear  = dq.clear;

endmodule

// File: rtl/cc_l2_trigger.sv
module cc_l2_trigger #(
    parameter int N_SEC     = 4,
    parameter int N_HAD     = 49,
    parameter int N_EL      = 36,
    parameter int DLY_DEPTH = 256,
    parameter int WIN       = 8,
    parameter int TMO       = 200,
    parameter int CNT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DLY_DEPTH)-1:0] dly_cfg,
    input  logic                         map_we,
    input  logic [$clog2(N_HAD)-1:0]     map_row,
    input  logic [N_EL-1:0]              map_data,
    input  logic                         l1_trig,
    input  logic [N_SEC*N_EL-1:0]        el_bits,
    input  logic [N_SEC*N_HAD-1:0]       had_bits,
    output logic                         l2_accept,
    output logic                         fast_clear,
    output logic [CNT_W-1:0]             acc_cnt,
    output logic [CNT_W-1:0]             tmo_cnt
);
    logic [N_HAD*N_EL-1:0] map_flat;
    logic [N_SEC-1:0]      sec_hit;

    cc_corr_map #(.N_HAD(N_HAD), .N_EL(N_EL)) u_map (
        .clk(clk), .rst(rst), .we(map_we), .row(map_row),
        .data(map_data), .map_flat(map_flat)
    );

    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
        logic [N_EL-1:0] win_open;

        cc_el_delay #(.N_EL(N_EL), .DLY_DEPTH(DLY_DEPTH), .WIN(WIN)) u_dly (
            .clk(clk), .rst(rst), .dly(dly_cfg),
            .el_in(el_bits[s*N_EL +: N_EL]), .win_open(win_open)
        );

        cc_sec_match #(.N_HAD(N_HAD), .N_EL(N_EL)) u_match (
            .clk(clk), .rst(rst), .had_in(had_bits[s*N_HAD +: N_HAD]),
            .win_open(win_open), .map_flat(map_flat), .sec_hit(sec_hit[s])
        );
    end

    cc_decide #(.TMO(TMO), .CNT_W(CNT_W)) u_dec (
        .clk(clk), .rst(rst), .l1(l1_trig), .any_hit(|sec_hit),
        .accept(l2_accept), .clear(fast_clear),
        .acc_cnt(acc_cnt), .tmo_cnt(tmo_cnt)
    );

endmodule

// File: rtl/cc_l2_trigger_chk.sv
module cc_l2_trigger_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             l2_accept,
    input logic             fast_clear,
    input logic [CNT_W-1:0] acc_cnt,
    input logic [CNT_W-1:0] tmo_cnt
);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(l2_accept && fast_clear));

    a_r5_accept_one_cycle: assert property (@(posedge clk) disable iff (rst)
        l2_accept |=> !l2_accept);

    a_r6_clear_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fast_clear |=> !fast_clear);

    a_r8_acc_moves_with_accept: assert property (@(posedge clk) disable iff (rst)
        (acc_cnt != $past(acc_cnt)) |-> (l2_accept && acc_cnt == $past(acc_cnt) + 1'b1));

    a_r8_tmo_moves_with_clear: assert property (@(posedge clk) disable iff (rst)
        (tmo_cnt != $past(tmo_cnt)) |-> (fast_clear && tmo_cnt == $past(tmo_cnt) + 1'b1));

    a_r8_acc_saturates: assert property (@(posedge clk) disable iff (rst)
        (acc_cnt == '1) |=> (acc_cnt == '1));

endmodule

bind cc_l2_trigger cc_l2_trigger_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .l2_accept(l2_accept), .fast_clear(fast_clear),
    .acc_cnt(acc_cnt), .tmo_cnt(tmo_cnt)
);

// File: tb/cc_l2_trigger_tb.sv
module cc_l2_trigger_tb;
    localparam int N_SEC = 4;
    localparam int N_HAD = 49;
    localparam int N_EL  = 36;
    localparam int DEPTH = 256;
    localparam int WIN   = 8;
    localparam int TMO   = 200;
    localparam int CW    = 3;
    localparam int AW    = $clog2(DEPTH);
    localparam int RW    = $clog2(N_HAD);
    localparam int SPAN  = TMO + 60;

    // fields: had section, had idx, el section, el idx, rel, delay, map allows pair, expect accept
    localparam int NV = 10;
    localparam int VEC [NV][8] = '{
        '{0,  0, 0,  0, 1,   0, 1, 1},
        '{0,  5, 0,  7, 0,  10, 1, 0},
        '{1, 20, 1,  3, 8,  25, 1, 1},
        '{2, 48, 2, 35, 9,  25, 1, 0},
        '{3, 12, 3, 30, 4, 100, 1, 1},
        '{1,  9, 1,  4, 3,   5, 0, 0},
        '{2, 30, 1, 30, 3,   5, 1, 0},
        '{3, 48, 3,  0, 5, 150, 1, 1},
        '{0,  1, 0, 35, 2, 190, 1, 1},
        '{0,  2, 0,  6, 1, 198, 1, 0}
    };

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [AW-1:0]          dly_cfg = '0;
    logic                   map_we = 1'b0;
    logic [RW-1:0]          map_row = '0;
    logic [N_EL-1:0]        map_data = '0;
    logic                   l1_trig = 1'b0;
    logic [N_SEC*N_EL-1:0]  el_bits = '0;
    logic [N_SEC*N_HAD-1:0] had_bits = '0;
    logic                   l2_accept;
    logic                   fast_clear;
    logic [CW-1:0]          acc_cnt;
    logic [CW-1:0]          tmo_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_acc = 0;
    int exp_tmo = 0;

    always #5 clk = ~clk;

    cc_l2_trigger #(
        .N_SEC(N_SEC), .N_HAD(N_HAD), .N_EL(N_EL), .DLY_DEPTH(DEPTH),
        .WIN(WIN), .TMO(TMO), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst(rst), .dly_cfg(dly_cfg), .map_we(map_we),
        .map_row(map_row), .map_data(map_data), .l1_trig(l1_trig),
        .el_bits(el_bits), .had_bits(had_bits), .l2_accept(l2_accept),
        .fast_clear(fast_clear), .acc_cnt(acc_cnt), .tmo_cnt(tmo_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_row(input int row, input logic [N_EL-1:0] data);
        @(negedge clk);
        map_we   = 1'b1;
        map_row  = RW'(row);
        map_data = data;
        @(negedge clk);
        map_we   = 1'b0;
        map_data = '0;
    endtask

    // Edge i follows the negedge of iteration i; outputs seen at iteration i come from edge i-1.
    task automatic run_case(input int sh, input int h, input int se, input int e,
                            input int rel, input int dly, input int l1a, input int l1b,
                            output int acc_e, output int clr_e,
                            output int n_acc, output int n_clr);
        int d;
        d = (rel < 0) ? -100 : 1 + dly + rel;
        acc_e = -1; clr_e = -1; n_acc = 0; n_clr = 0;
        dly_cfg = AW'(dly);
        for (int i = 0; i <= SPAN; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (l2_accept) begin
                    if (acc_e < 0) acc_e = i - 1;
                    n_acc++;
                end
                if (fast_clear) begin
                    if (clr_e < 0) clr_e = i - 1;
                    n_clr++;
                end
            end
            l1_trig  = (i == l1a) || (i == l1b);
            el_bits  = '0;
            had_bits = '0;
            if (i == 1) el_bits[se*N_EL + e] = 1'b1;
            if (i == d) had_bits[sh*N_HAD + h] = 1'b1;
        end
        @(negedge clk);
        l1_trig  = 1'b0;
        el_bits  = '0;
        had_bits = '0;
    endtask

    task automatic check_counts(input string tag);
        chk(acc_cnt == CW'(exp_acc), "R8", {tag, " acc_cnt"}, int'(acc_cnt), exp_acc);
        chk(tmo_cnt == CW'(exp_tmo), "R8", {tag, " tmo_cnt"}, int'(tmo_cnt), exp_tmo);
    endtask

    function automatic int sat(input int v);
        return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int acc_e, clr_e, n_acc, n_clr;
        logic [N_EL-1:0] row;

        // R1: reset state at the ports
        idle(4);
        chk(l2_accept == 1'b0, "R1", "accept in reset", int'(l2_accept), 0);
        chk(fast_clear == 1'b0, "R1", "clear in reset", int'(fast_clear), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(acc_cnt == '0 && tmo_cnt == '0, "R1", "counters after reset",
            int'(acc_cnt) + int'(tmo_cnt), 0);

        // R1: reset wipes the correlation map
        write_row(0, N_EL'(1));
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(DEPTH + 10);
        run_case(0, 0, 0, 0, 1, 0, 0, -1, acc_e, clr_e, n_acc, n_clr);
        chk(acc_e == -1, "R1", "accept with cleared map", acc_e, -1);
        chk(clr_e == TMO, "R1", "clear edge with cleared map", clr_e, TMO);
        exp_tmo = sat(exp_tmo + 1);
        check_counts("R1");

        // R2 R3 R4 R5 R6 R8: table of cases
        for (int v = 0; v < NV; v++) begin
            int dd;
            row = '0;
            row[VEC[v][6] != 0 ? VEC[v][3] : (VEC[v][3] ^ 1)] = 1'b1;
            write_row(VEC[v][1], row);
            idle(DEPTH + WIN + 10);
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                     0, -1, acc_e, clr_e, n_acc, n_clr);
            dd = 1 + VEC[v][5] + VEC[v][4];
            if (VEC[v][7] != 0) begin
                chk(acc_e == dd + 2, "R2/R5", $sformatf("vec %0d accept edge", v), acc_e, dd + 2);
                chk(n_clr == 0, "R5", $sformatf("vec %0d no clear", v), n_clr, 0);
                exp_acc = sat(exp_acc + 1);
            end else begin
                chk(acc_e == -1, "R2/R3/R4", $sformatf("vec %0d no accept", v), acc_e, -1);
                chk(clr_e == TMO, "R6", $sformatf("vec %0d clear edge", v), clr_e, TMO);
                exp_tmo = sat(exp_tmo + 1);
            end
            check_counts($sformatf("vec %0d", v));
            write_row(VEC[v][1], '0);
        end

        // R7: coincidence while idle is ignored
        write_row(11, N_EL'(1) << 2);
        idle(DEPTH + WIN + 10);
        run_case(2, 11, 2, 2, 1, 0, 30, -1, acc_e, clr_e, n_acc, n_clr);
        chk(n_acc == 0, "R7", "accepts from idle coincidence", n_acc, 0);
        chk(clr_e == 30 + TMO, "R7", "clear edge after late l1", clr_e, 30 + TMO);
        exp_tmo = sat(exp_tmo + 1);
        check_counts("R7 idle");

        // R7: second level-one inside the period does not extend it
        idle(WIN + 10);
        run_case(0, 0, 0, 0, -1, 0, 0, 50, acc_e, clr_e, n_acc, n_clr);
        chk(clr_e == TMO, "R7", "clear edge with extra l1", clr_e, TMO);
        chk(n_clr == 1, "R6/R7", "clear pulse count", n_clr, 1);
        exp_tmo = sat(exp_tmo + 1);
        check_counts("R8 saturation");
        chk(tmo_cnt == '1, "R8", "tmo_cnt held at all ones", int'(tmo_cnt), (1 << CW) - 1);

        // R9: exclusivity observed over a run with an accept at the last legal edge
        write_row(7, N_EL'(1) << 9);
        idle(DEPTH + WIN + 10);
        run_case(1, 7, 1, 9, 1, TMO - 4, 0, -1, acc_e, clr_e, n_acc, n_clr);
        chk(acc_e == TMO && clr_e == -1, "R9", "accept wins at final edge", acc_e, TMO);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule